// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the low-order address bits for a burst of four beats. A burst opens when a load strobe captures an externally supplied starting value. Each later advance request moves the output to the next beat, either counting upward modulo four (linear order) or flipping bits of the starting value with a two-bit beat count (interleaved order). A static order-select input chooses between the two orders.

The output is meant to be joined with upper address bits that a separate register holds. Only the low bits move during a burst. When advance is not requested, the block inserts a wait cycle and holds the current address. After the fourth beat, the next advance returns to the first address of the same burst. A load always restarts the sequence. Tie-off logic outside the block should drive order-select high when the input is left open, so that an unconnected selector picks interleaved order.

Top module: `burst_low_addr`

## Requirements
- R1: While reset (`rst_n` low) is active, and in the first cycle after it is released, `low_addr_o` is 00.
- R2: One cycle after a clock edge on which `load_i` is high, `low_addr_o` equals the `load_addr_i` value that was sampled on that edge.
- R3: With `order_sel_i` = 1 (interleaved), the output after the k-th advance since the last load is the start value XOR k (mod 4). A start of 01 gives 01, 00, 11, 10.
- R4: With `order_sel_i` = 0 (linear), the output after the k-th advance since the last load is the start value plus k, modulo 4. A start of 11 gives 11, 00, 01, 10.
- R5: On an edge where both `load_i` and `step_i` are low, `low_addr_o` keeps its value (a wait cycle).
- R6: The fourth advance after a load returns `low_addr_o` to the start value, and further advances repeat the same four-beat sequence.
- R7: When `load_i` and `step_i` are both high on the same edge, the load wins. The output becomes the new start value, and the following advance yields the second beat of the new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture `load_addr_i` as a new burst start |
| load_addr_i | input | LOW_W | External low address bits for the burst start |
| step_i | input | 1 | Advance to the next beat; low means wait |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order; static |
| low_addr_o | output | LOW_W | Current low address bits |

## Verification
A load and an advance can arrive on the same edge. The bench provokes this by raising both strobes part-way through a running burst. It then requires the output to show the new start value one cycle later, and the next advance to give the second beat of the new sequence, not a beat that continues the old count. The rest of the bench runs every start value in both orders, inserts wait cycles between beats, and advances past the fourth beat to confirm the wrap.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst low-address sequencer.
package burst_seq_pkg;
    // Beat ordering selected by the static order input.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/beat_start_reg.sv
// Holds the burst start value captured on a load strobe.
// Assumes load_i is a single-cycle qualifier sampled on the rising edge.
module beat_start_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] addr_i,
    output logic [W-1:0] start_o
);
    // Capture the external start bits on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      start_o <= '0;
        else if (load_i) start_o <= addr_i;
    end
endmodule

// File: rtl/beat_counter.sv
// Beat position counter within the burst, wrapping at 2**W beats.
// Assumes clear_i has priority over step_i.
module beat_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o
);
    // Restart on clear, advance on step, otherwise hold (wait cycle).
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_o <= '0;
        else if (clear_i) cnt_o <= '0;
        else if (step_i)  cnt_o <= cnt_o + W'(1);
    end
endmodule

// File: rtl/beat_addr_mix.sv
// Combines start value and beat count into the current low address.
// Interleaved order XORs bit by bit; linear order adds with natural wrap.
module beat_addr_mix
    import burst_seq_pkg::*;
#(
    parameter int W = 2
) (
    input  order_e       order_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] addr_o
);
    logic [W-1:0] xor_addr;
    logic [W-1:0] sum_addr;

    // Per-bit interleave: each address bit flips with its count bit.
    for (genvar b = 0; b < W; b++) begin : g_ilv
        assign xor_addr[b] = start_i[b] ^ cnt_i[b];
    end

    // Linear order: modulo-2**W sum.
    assign sum_addr = start_i + cnt_i;

    // Pick the ordering named by the static order input.
    always_comb begin
        addr_o = (order_i == ORD_INTERLEAVE) ? xor_addr : sum_addr;
    end
endmodule

// File: rtl/burst_low_addr.sv
// Burst low-address sequencer top.
// Output follows start and beat registers through a combinational mix,
// so it changes one cycle after load or step. order_sel_i is static.
module burst_low_addr
    import burst_seq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LOW_W-1:0] load_addr_i,
    input  logic             step_i,
    input  logic             order_sel_i,
    output logic [LOW_W-1:0] low_addr_o
);
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] cnt_q;
    order_e           order;

    // Map the raw selector onto the ordering type.
    assign order = order_e'(order_sel_i);

    beat_start_reg #(.W(LOW_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .addr_i  (load_addr_i),
        .start_o (start_q)
    );

    beat_counter #(.W(LOW_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .step_i  (step_i),
        .cnt_o   (cnt_q)
    );

    beat_addr_mix #(.W(LOW_W)) u_mix (
        .order_i (order),
        .start_i (start_q),
        .cnt_i   (cnt_q),
        .addr_o  (low_addr_o)
    );
endmodule

// File: rtl/burst_low_addr_chk.sv
// Property checker for burst_low_addr, attached through bind.
module burst_low_addr_chk #(
    parameter int LOW_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [LOW_W-1:0] load_addr_i,
    input logic             step_i,
    input logic             order_sel_i,
    input logic [LOW_W-1:0] low_addr_o,
    input logic [LOW_W-1:0] start_q,
    input logic [LOW_W-1:0] cnt_q
);
    a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> low_addr_o == $past(load_addr_i));

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=>
            ((order_sel_i != $past(order_sel_i)) || $stable(low_addr_o)));

    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !order_sel_i) |=>
            (order_sel_i || low_addr_o == LOW_W'($past(low_addr_o) + 1'b1)));

    a_r3_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && order_sel_i) |=>
            (!order_sel_i ||
             (low_addr_o ^ start_q) == LOW_W'(($past(low_addr_o) ^ $past(start_q)) + 1'b1)));

    a_r6_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cnt_q == '1) |=> low_addr_o == start_q);

    a_r7_load_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && step_i) |=> (cnt_q == '0 && low_addr_o == $past(load_addr_i)));
endmodule

bind burst_low_addr burst_low_addr_chk #(.LOW_W(LOW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .step_i      (step_i),
    .order_sel_i (order_sel_i),
    .low_addr_o  (low_addr_o),
    .start_q     (start_q),
    .cnt_q       (cnt_q)
);

// File: tb/burst_low_addr_bench.sv
`timescale 1ns/1ps
// Directed bench for burst_low_addr: one task per scenario.
module burst_low_addr_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_i;
    logic [1:0] load_addr_i;
    logic       step_i;
    logic       order_sel_i;
    logic [1:0] low_addr_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    burst_low_addr u_burst_low_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .step_i      (step_i),
        .order_sel_i (order_sel_i),
        .low_addr_o  (low_addr_o)
    );

    // Compare and count one result.
    task automatic check(input logic [1:0] exp, input string req);
        n_run++;
        if (low_addr_o !== exp) begin
            n_fail++;
            $display("FAIL %s: low_addr_o=%b expected=%b", req, low_addr_o, exp);
        end
    endtask

    // Apply one edge with the given strobes, then sample after it.
    task automatic cycle(input logic ld, input logic [1:0] a, input logic st);
        @(negedge clk);
        load_i = ld; load_addr_i = a; step_i = st;
        @(posedge clk); #1;
        load_i = 1'b0; step_i = 1'b0;
    endtask

    // Expected beat k for start s in the chosen order.
    function automatic logic [1:0] beat(input logic [1:0] s, input int k, input logic ilv);
        logic [1:0] kk = 2'(k);
        return ilv ? (s ^ kk) : 2'(s + kk);
    endfunction

    // R1: reset value and first cycle after release.
    task automatic t_reset();
        rst_n = 1'b0; load_i = 1'b0; load_addr_i = 2'b11; step_i = 1'b1; order_sel_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 check(2'b00, "R1 during reset");
        @(negedge clk); rst_n = 1'b1; step_i = 1'b0;
        @(posedge clk); #1 check(2'b00, "R1 after release");
    endtask

    // R2/R3/R4/R5/R6: full burst with optional waits, plus a wrapped round.
    task automatic t_burst(input logic [1:0] s, input logic ilv, input bit waits);
        string rq = ilv ? "R3" : "R4";
        @(negedge clk); order_sel_i = ilv;
        cycle(1'b1, s, 1'b0);
        check(s, "R2 load start");
        for (int k = 1; k <= 6; k++) begin
            if (waits) begin
                cycle(1'b0, 2'b00, 1'b0);
                check(beat(s, k - 1, ilv), "R5 wait holds");
            end
            cycle(1'b0, ~s, 1'b1);
            if (k == 4) check(s, "R6 wrap to start");
            else        check(beat(s, k, ilv), rq);
        end
    endtask

    // R7: load and step on the same edge mid-burst.
    task automatic t_collide(input logic ilv);
        @(negedge clk); order_sel_i = ilv;
        cycle(1'b1, 2'b01, 1'b0);
        cycle(1'b0, 2'b00, 1'b1);
        cycle(1'b0, 2'b00, 1'b1);
        cycle(1'b1, 2'b10, 1'b1);
        check(2'b10, "R7 load wins output");
        cycle(1'b0, 2'b00, 1'b1);
        check(beat(2'b10, 1, ilv), "R7 next beat of new burst");
    endtask

    initial begin
        t_reset();
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) begin
                t_burst(2'(s), m[0], 1'b0);
                t_burst(2'(s), m[0], 1'b1);
            end
        t_collide(1'b1);
        t_collide(1'b0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: finished=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule